// File: doc/BRIEF.md
# Windowed Power-Cap Stop-Cycle Controller

This block keeps the average power of an accelerator or CPU under a budget set by software. Time is cut into fixed epochs of 100 clock cycles. In each epoch a power monitor delivers one power estimate. The block smooths that estimate with a first-order low-pass filter and compares the result with the budget. It then runs an integrating pole/zero compensator whose gain software can set. The result is a count of stop cycles that the freeze logic downstream applies in the same epoch. Only shifts and adds are used. The filter and the compensator each take one clock cycle.

Software reaches four 32-bit registers through a plain read/write port: the budget, the last power sample, an application status word and the compensator gain. Software reloads the gain whenever an application starts, choosing a value that keeps the loop stable for that workload. The stop count is limited to 94, because the first six cycles of every epoch are set aside for computing and applying the actuation.

Top module: `pwrcap_ctrl`

## Requirements
- R1: `valid_out` is high for exactly one cycle once every 100 cycles. Its first high cycle follows the second rising clock edge after reset is released.
- R2: All power values are unsigned fixed point with 8 fractional bits. At the start of each epoch the filter state y is replaced by floor(y/4)+floor(y/16)+x-floor(x/4)-floor(x/16), where x is the latest captured sample. This gives a pole of 0.3125.
- R3: One cycle after the filter update, the error e = y - budget is formed, and the integrator C becomes C + k*(e - floor(e'/2) - floor(e'/4)), where e' is the error from the previous epoch (0 after reset).
- R4: The gain register holds three byte fields at bits [7:0], [15:8] and [23:16]. In each field, bit 7 enables the term and bits [2:0] hold an exponent s. For an input d, each enabled term adds floor(d*2^s/16). With no field enabled the integrator does not change. The reset value is 0x84, which gives k = 1.
- R5: After each update the integrator is clamped to the range 0 to 94*256, so it never winds up beyond the output limits. `stop_cnt` = floor(C/256) never exceeds 94.
- R6: Register addresses: 0 = budget (read/write, low 24 bits), 1 = last power sample (read-only; writes have no effect), 2 = status, 3 = gain. After reset all of them read 0 except the gain.
- R7: A sample presented with `sample_vld` can be read at address 1 from the next cycle. The filter uses the most recent sample captured before the epoch starts.
- R8: Status bit 0 is set by `app_start` and cleared by `app_done`, and bus writes cannot change it. Bits 31:1 are written by the bus.
- R9: While reset is held, and right after it, `stop_cnt` is 0 and `valid_out` is low.
- R10: `stop_cnt` changes only in a cycle where `valid_out` is high, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_vld | input | 1 | Marks a valid power sample on `pwr_in` |
| pwr_in | input | 24 | Power estimate, 8 fractional bits |
| app_start | input | 1 | Application start event |
| app_done | input | 1 | Application end event |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| stop_cnt | output | 7 | Stop cycles for the current epoch |
| valid_out | output | 1 | One-cycle pulse marking a new stop count |

## Verification
A new stop count appears two rising edges after the epoch boundary: one edge for the filter and one for the compensator. The pulse then repeats every 100 cycles. The bench therefore waits for `valid_out` at falling edges, compares the count with its own model in that same cycle, and checks that the next cycle is low and that the gap from the previous pulse is 100. A register write or a sample takes effect on the rising edge after it is driven, so readback is sampled one falling edge later. New inputs for the loop are applied just after a pulse, well before the next epoch boundary, so the model and the design always consume the same values.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int FRAC = 8;
  localparam int AW   = 40;
  typedef logic signed [AW-1:0] acc_t;

  // first-order smoothing, pole 0.3125
  function automatic acc_t lpf_next(acc_t y, acc_t x);
    return (y >>> 2) + (y >>> 4) + x - (x >>> 2) - (x >>> 4);
  endfunction

  // sum of up to three power-of-two terms, each (d << s) >> 4
  function automatic acc_t gain_apply(acc_t d, logic [23:0] g);
    acc_t acc;
    acc = '0;
    for (int i = 0; i < 3; i++) begin
      if (g[8*i+7]) acc = acc + ((d <<< g[8*i +: 3]) >>> 4);
    end
    return acc;
  endfunction

  // integrator with zero at 0.75, clamped to [0, cmax]
  function automatic acc_t comp_next(acc_t cprev, acc_t e, acc_t eprev,
                                     logic [23:0] g, acc_t cmax);
    acc_t d;
    acc_t s;
    d = e - ((eprev >>> 1) + (eprev >>> 2));
    s = cprev + gain_apply(d, g);
    if (s < 0)         return '0;
    else if (s > cmax) return cmax;
    else               return s;
  endfunction
endpackage

// File: rtl/pcap_regs.sv
module pcap_regs #(
  parameter int DW = 32,
  parameter int PW = 24,
  parameter logic [23:0] GAIN_RST = 24'h000084
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sample_vld,
  input  logic [PW-1:0] pwr_in,
  input  logic          app_start,
  input  logic          app_done,
  output logic [PW-1:0] budget_q,
  output logic [PW-1:0] act_q,
  output logic [23:0]   gain_q,
  output logic [DW-1:0] status_q
);
  localparam logic [1:0] A_BUD  = 2'd0;
  localparam logic [1:0] A_ACT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_GAIN = 2'd3;

  logic wr;
  assign wr = bus_en && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
      act_q    <= '0;
      gain_q   <= GAIN_RST;
      status_q <= '0;
    end else begin
      if (wr && bus_addr == A_BUD)  budget_q <= bus_wdata[PW-1:0];
      if (wr && bus_addr == A_GAIN) gain_q   <= bus_wdata[23:0];
      if (wr && bus_addr == A_STAT) status_q[DW-1:1] <= bus_wdata[DW-1:1];
      if (app_start)     status_q[0] <= 1'b1;
      else if (app_done) status_q[0] <= 1'b0;
      if (sample_vld) act_q <= pwr_in;
    end
  end

  always_comb begin
    case (bus_addr)
      A_BUD:   bus_rdata = DW'(budget_q);
      A_ACT:   bus_rdata = DW'(act_q);
      A_STAT:  bus_rdata = status_q;
      default: bus_rdata = DW'(gain_q);
    endcase
  end
endmodule

// File: rtl/pcap_epoch.sv
module pcap_epoch #(
  parameter int EPOCH = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic filt_fire,
  output logic comp_fire
);
  localparam int CW = $clog2(EPOCH);
  localparam logic [CW-1:0] LAST = CW'(EPOCH - 1);

  logic [CW-1:0] ep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ep_q <= '0;
    else if (ep_q == LAST) ep_q <= '0;
    else                   ep_q <= ep_q + 1'b1;
  end

  assign filt_fire = (ep_q == '0);
  assign comp_fire = (ep_q == CW'(1));
endmodule

// File: rtl/pcap_lpf.sv
module pcap_lpf #(
  parameter int PW = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [PW-1:0]      x,
  output pcap_pkg::acc_t     y_q
);
  import pcap_pkg::*;
  acc_t x_ext;
  assign x_ext = $signed({{(AW-PW){1'b0}}, x});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_q <= '0;
    else if (fire) y_q <= lpf_next(y_q, x_ext);
  end
endmodule

// File: rtl/pcap_comp.sv
module pcap_comp #(
  parameter int PW   = 24,
  parameter int CMAX = 94 * 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  pcap_pkg::acc_t     y,
  input  logic [PW-1:0]      budget,
  input  logic [23:0]        gain,
  output pcap_pkg::acc_t     c_q,
  output logic               valid_q
);
  import pcap_pkg::*;
  localparam acc_t CLIM = acc_t'(CMAX);

  acc_t e_now;
  acc_t e_prev_q;
  assign e_now = y - $signed({{(AW-PW){1'b0}}, budget});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q      <= '0;
      e_prev_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        c_q      <= comp_next(c_q, e_now, e_prev_q, gain, CLIM);
        e_prev_q <= e_now;
      end
    end
  end
endmodule

// File: rtl/pwrcap_ctrl.sv
module pwrcap_ctrl #(
  parameter int EPOCH    = 100,
  parameter int RESERVED = 6,
  parameter int PW       = 24,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic [PW-1:0] pwr_in,
  input  logic          app_start,
  input  logic          app_done,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [6:0]    stop_cnt,
  output logic          valid_out
);
  import pcap_pkg::*;
  localparam int STOP_MAX = EPOCH - RESERVED;
  localparam int SW       = 7;
  localparam int CMAX     = STOP_MAX << FRAC;

  logic [PW-1:0] budget_q;
  logic [PW-1:0] act_q;
  logic [23:0]   gain_q;
  logic [DW-1:0] status_q;
  logic          filt_fire;
  logic          comp_fire;
  logic          app_running;
  acc_t          y_q;
  acc_t          c_q;

  assign app_running = status_q[0];

  pcap_regs #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sample_vld(sample_vld), .pwr_in(pwr_in), .app_start(app_start),
    .app_done(app_done), .budget_q(budget_q), .act_q(act_q),
    .gain_q(gain_q), .status_q(status_q)
  );

  pcap_epoch #(.EPOCH(EPOCH)) u_epoch (
    .clk(clk), .rst_n(rst_n), .filt_fire(filt_fire), .comp_fire(comp_fire)
  );

  pcap_lpf #(.PW(PW)) u_lpf (
    .clk(clk), .rst_n(rst_n), .fire(filt_fire), .x(act_q), .y_q(y_q)
  );

  pcap_comp #(.PW(PW), .CMAX(CMAX)) u_comp (
    .clk(clk), .rst_n(rst_n), .fire(comp_fire), .y(y_q), .budget(budget_q),
    .gain(gain_q), .c_q(c_q), .valid_q(valid_out)
  );

  assign stop_cnt = c_q[FRAC +: SW];
endmodule

// File: rtl/pcap_chk.sv
module pcap_chk #(
  parameter int EPOCH    = 100,
  parameter int STOP_MAX = 94,
  parameter int PW       = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_out,
  input logic [6:0]    stop_cnt,
  input logic          sample_vld,
  input logic [PW-1:0] pwr_in,
  input logic [PW-1:0] act_q,
  input logic          app_start,
  input logic          app_done,
  input logic          app_running
);
  localparam int GW = $clog2(EPOCH + 1) + 1;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_out) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);
  // R1
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && seen_q) |-> (gap_q == GW'(EPOCH)));
  // R5
  stop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cnt <= 7'(STOP_MAX));
  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> $stable(stop_cnt));
  // R7
  sample_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> (act_q == $past(pwr_in)));
  // R8
  app_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_start |=> app_running);
  // R8
  app_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (app_done && !app_start) |=> !app_running);
endmodule

bind pwrcap_ctrl pcap_chk #(.EPOCH(EPOCH), .STOP_MAX(STOP_MAX), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_out(valid_out), .stop_cnt(stop_cnt),
  .sample_vld(sample_vld), .pwr_in(pwr_in), .act_q(act_q),
  .app_start(app_start), .app_done(app_done), .app_running(app_running)
);

// File: tb/pwrcap_ctrl_tb.sv
module pwrcap_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sample_vld = 0;
  logic [23:0] pwr_in = 0;
  logic        app_start = 0, app_done = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [6:0]  stop_cnt;
  logic        valid_out;

  pwrcap_ctrl u_dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  longint cyc = 0;
  longint last_v = -1;
  always @(posedge clk) cyc++;

  // independent model state
  longint m_y, m_c, m_ep, m_x, m_b, m_g;

  localparam int NV = 12;
  localparam int REPS = 3;
  localparam int unsigned V_PWR [NV] = '{25600, 25600, 10240, 40960, 40960, 64000,
                                         64000, 0, 23040, 19200, 51200, 31616};
  localparam int unsigned V_BUD [NV] = '{19200, 19200, 19200, 28160, 40960, 10240,
                                         10240, 40960, 19200, 19200, 10240, 25600};
  localparam int unsigned V_GAIN[NV] = '{32'h80, 32'h84, 32'h84, 32'h8385, 32'h8385,
                                         32'h818485, 32'h818485, 32'h84, 32'h82,
                                         32'h87, 32'h00, 32'h86};

  function automatic longint fdiv(longint a, longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  task automatic model_reset();
    m_y = 0; m_c = 0; m_ep = 0; m_x = 0; m_b = 0; m_g = 'h84;
  endtask

  task automatic model_step();
    longint e, d, add, f;
    m_y = m_y / 4 + m_y / 16 + m_x - m_x / 4 - m_x / 16;
    e = m_y - m_b;
    d = e - (fdiv(m_ep, 2) + fdiv(m_ep, 4));
    add = 0;
    for (int i = 0; i < 3; i++) begin
      f = (m_g >> (8 * i)) & 255;
      if ((f & 128) != 0) add += fdiv(d * (longint'(1) << (f & 7)), 16);
    end
    m_c = m_c + add;
    if (m_c < 0) m_c = 0;
    if (m_c > 94 * 256) m_c = 94 * 256;
    m_ep = e;
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic give_sample(logic [23:0] v);
    sample_vld = 1; pwr_in = v;
    @(negedge clk);
    sample_vld = 0;
    m_x = v;
  endtask

  // wait for the pulse, compare, confirm the pulse ends; returns wait count
  task automatic step(string tag, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!valid_out && n < 300);
    model_step();
    chk(stop_cnt == m_c / 256, tag, stop_cnt, m_c / 256);
    if (last_v >= 0) chk(cyc - last_v == 100, "R1 pulse spacing", cyc - last_v, 100);
    last_v = cyc;
    @(negedge clk);
    chk(valid_out == 0, "R1 pulse width", valid_out, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(stop_cnt == 0 && valid_out == 0, "R9 outputs in reset", stop_cnt, 0);
    rst_n = 1;
    model_reset();
    last_v = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    model_reset();
    do_reset();
    // reset register state (R6, R4)
    bus_read(2'd0, rd); chk(rd == 0, "R6 budget reset", rd, 0);
    bus_read(2'd1, rd); chk(rd == 0, "R6 sample reset", rd, 0);
    bus_read(2'd2, rd); chk(rd == 0, "R6 status reset", rd, 0);
    bus_read(2'd3, rd); chk(rd == 32'h84, "R4 gain reset", rd, 32'h84);
    chk(stop_cnt == 0, "R9 stop after reset", stop_cnt, 0);
    // first pulse after second edge (R1)
    step("R3 first count", n);
    chk(n == 2, "R1 first pulse timing", n, 2);

    // vector table walk (R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd0, V_BUD[i]);  m_b = V_BUD[i];
      bus_write(2'd3, V_GAIN[i]); m_g = V_GAIN[i];
      give_sample(V_PWR[i][23:0]);
      for (int r = 0; r < REPS; r++) step("R2 R3 R4 R5 vector count", n);
    end

    // drive to zero, then one epoch over budget: no windup (R5)
    bus_write(2'd0, 40960); m_b = 40960;
    bus_write(2'd3, 32'h84); m_g = 'h84;
    give_sample(0);
    for (int r = 0; r < 6; r++) step("R5 low side", n);
    chk(stop_cnt == 0, "R5 clamp at zero", stop_cnt, 0);
    bus_write(2'd0, 19200); m_b = 19200;
    give_sample(40960);
    step("R5 recovery count", n);
    chk(stop_cnt > 0, "R5 no windup", stop_cnt, 1);

    // read-only sample register (R6) and capture (R7)
    give_sample(24'h001234);
    bus_read(2'd1, rd); chk(rd == 32'h1234, "R7 sample readback", rd, 32'h1234);
    bus_write(2'd1, 32'hABCD);
    bus_read(2'd1, rd); chk(rd == 32'h1234, "R6 read-only sample", rd, 32'h1234);
    bus_write(2'd0, 32'h00FF_FFFF);
    bus_read(2'd0, rd); chk(rd == 32'h00FF_FFFF, "R6 budget readback", rd, 32'h00FF_FFFF);

    // status bit handling (R8)
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, rd); chk(rd == 32'hFFFF_FFFE, "R8 bus write bit0", rd, 32'hFFFF_FFFE);
    app_start = 1; @(negedge clk); app_start = 0;
    bus_read(2'd2, rd); chk(rd[0] == 1, "R8 start sets", rd[0], 1);
    bus_write(2'd2, 32'h0);
    bus_read(2'd2, rd); chk(rd == 32'h1, "R8 write keeps bit0", rd, 1);
    app_done = 1; @(negedge clk); app_done = 0;
    bus_read(2'd2, rd); chk(rd == 0, "R8 done clears", rd, 0);

    // hold between pulses (R10)
    begin
      logic [6:0] held;
      held = stop_cnt;
      repeat (20) begin
        @(negedge clk);
        if (!valid_out) chk(stop_cnt == held, "R10 hold", stop_cnt, held);
        else held = stop_cnt;
      end
    end

    // mid-run reset (R9 R6)
    do_reset();
    bus_read(2'd0, rd); chk(rd == 0, "R6 budget after reset", rd, 0);
    step("R9 count after reset", n);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule